// File: doc/BRIEF.md
# SDRAM Bank Timing Gate

This block sits on the controller side of an SDRAM interface. It follows the state of each internal bank and decides, cycle by cycle, whether a decoded command may go to the memory. The command comes in as a 4-bit code with a bank number. The gate answers in two ways. It drives a set of "may issue" flags, one per command type and bank, so a scheduler can choose a legal command before it presents one. It also raises a violation flag in the same cycle if the presented command breaks a spacing rule. A command that raises the violation flag is dropped and changes no state. Every timing value is a clock count set through a parameter.

Each bank runs a small state machine with four states. IDLE means closed and ready. OPEN means a row is active. AUTO means a read or write with auto-precharge is in its burst, and the internal precharge is still pending. PRECH means a precharge is running and the tRP countdown is active. The transitions are as follows. IDLE goes to OPEN on an accepted activate. OPEN goes to AUTO on an accepted read or write with auto-precharge, and goes to PRECH on an accepted precharge or precharge-all. AUTO goes to PRECH when its internal precharge start point is reached. PRECH goes to OPEN on an accepted activate once tRP has elapsed, and otherwise falls back to IDLE when tRP ends. Next to the bank machines, a shared stage holds three counters and the burst-length code. The counters cover activate-to-activate spacing across banks, the activate block that follows a refresh, and the quiet time after a mode set.

Top module: `sdram_bank_gate`

## Requirements
- R1: After reset, every bank is IDLE and the burst-length code is 2 (four beats). With a NOP presented, all `may_act`, all `may_pre`, `may_prea`, `may_ref` and `may_mrs` are 1, all `may_rw`, `may_rda` and `may_wra` are 0, and `violation` is 0.
- R2: A read or write (codes 2 and 4) to a bank is legal no earlier than T_RCD cycles after the activate to that bank.
- R3: An activate (code 1) to a bank that is OPEN or AUTO is illegal. The bank must be precharged first.
- R4: Two activates to the same bank are at least T_RC cycles apart. A refresh (code 8) is legal only when every bank is idle with tRP expired. After a refresh, no activate is legal for T_RC cycles.
- R5: Activates to different banks are at least T_RRD cycles apart.
- R6: After a precharge to a bank, an activate to that bank is legal no earlier than T_RP cycles later.
- R7: A precharge (code 6) to an OPEN bank is legal only T_RAS or more cycles after its activate. A read or write with auto-precharge is legal only if its internal precharge start point falls T_RAS or more cycles after the activate.
- R8: For a read with auto-precharge (code 3) issued in cycle k with a burst of BL beats, the internal precharge starts in cycle k+BL. An activate to that bank is then legal from cycle k+BL+T_RP.
- R9: For a write with auto-precharge (code 5) issued in cycle k, the internal precharge starts in cycle k+BL-1+T_WR. An activate to that bank is then legal from cycle k+BL-1+T_WR+T_RP.
- R10: While a bank is AUTO, any read, write, precharge or precharge-all that touches it is illegal.
- R11: A mode set (code 9) is legal only when all banks are idle. It loads `mode_bl` as the burst-length code: 0, 1, 2 and 3 give 1, 2, 4 and 8 beats, and any code with bit 2 set means full page. For the next T_RSC-1 cycles every command except NOP is illegal. While the code means full page, both auto-precharge commands are illegal.
- R12: Reads and writes to an OPEN bank may issue on consecutive cycles.
- R13: Precharge-all (code 7) sends every OPEN bank to PRECH at once, each with its own tRP countdown. Banks that were already closed stay ready.
- R14: `violation` is 1 in the same cycle as any command whose matching may-flag is 0, and for the reserved codes 10 to 15. NOP (code 0) is always legal. A command that raises `violation` changes no bank or counter state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; commands are taken on the rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 4 | Command code (see R1 to R14) |
| bank | input | $clog2(NB) | Target bank of cmd |
| mode_bl | input | 3 | Burst-length code loaded by a mode set |
| may_act | output | NB | Activate is legal for each bank this cycle |
| may_rw | output | NB | Plain read or write is legal for each bank |
| may_rda | output | NB | Read with auto-precharge is legal for each bank |
| may_wra | output | NB | Write with auto-precharge is legal for each bank |
| may_pre | output | NB | Single-bank precharge is legal for each bank |
| may_prea | output | 1 | Precharge-all is legal |
| may_ref | output | 1 | Auto-refresh is legal |
| may_mrs | output | 1 | Mode set is legal |
| violation | output | 1 | Presented command is illegal and is dropped |

## Verification
The properties assume that `cmd` and `bank` are stable around the rising edge. They also assume that the bank number always lies within NB. The stimulus sets every command on the falling edge from a task and holds it through the next rising edge. It only ever uses bank numbers 0 to 3. The properties do not assume the commands are legal. The bench presents illegal commands on purpose to show that they are flagged and dropped, and the assertions are written to hold in that case too.

// File: rtl/sdram_gate_pkg.sv
package sdram_gate_pkg;

    typedef enum logic [3:0] {
        CMD_NOP  = 4'd0,
        CMD_ACT  = 4'd1,
        CMD_RD   = 4'd2,
        CMD_RDA  = 4'd3,
        CMD_WR   = 4'd4,
        CMD_WRA  = 4'd5,
        CMD_PRE  = 4'd6,
        CMD_PREA = 4'd7,
        CMD_REF  = 4'd8,
        CMD_MRS  = 4'd9
    } cmd_e;

    typedef enum logic [1:0] {
        BK_IDLE  = 2'd0,
        BK_OPEN  = 2'd1,
        BK_AUTO  = 2'd2,
        BK_PRECH = 2'd3
    } bank_state_e;

    localparam logic [2:0] BL_CODE_RESET = 3'd2;

endpackage

// File: rtl/sdram_bank_fsm.sv
module sdram_bank_fsm
    import sdram_gate_pkg::*;
#(
    parameter int CW    = 6,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RC  = 9,
    parameter int T_RP  = 3
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          act_go,
    input  logic          ap_go,
    input  logic          pre_go,
    input  logic [CW-1:0] ap_delay,
    output bank_state_e   state,
    output logic          rcd_ok,
    output logic          rc_ok,
    output logic          ready,
    output logic [CW-1:0] ras_left
);

    localparam logic [CW-1:0] LD_RCD = CW'(T_RCD - 1);
    localparam logic [CW-1:0] LD_RAS = CW'(T_RAS - 1);
    localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_RP  = CW'(T_RP - 1);

    bank_state_e   st_q, st_d;
    logic [CW-1:0] rcd_q, ras_q, rc_q, rp_q, ap_q;
    logic          ap_done, to_prech;

    function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    assign ap_done  = (ap_q == '0);
    assign to_prech = (st_q == BK_OPEN && !ap_go && pre_go) ||
                      (st_q == BK_AUTO && ap_done);

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= BK_IDLE;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            BK_IDLE:  if (act_go) st_d = BK_OPEN;
            BK_OPEN:  if (ap_go) st_d = BK_AUTO;
                      else if (pre_go) st_d = BK_PRECH;
            BK_AUTO:  if (ap_done) st_d = BK_PRECH;
            BK_PRECH: if (act_go) st_d = BK_OPEN;
                      else if (rp_q == '0) st_d = BK_IDLE;
            default:  st_d = BK_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rcd_q <= '0;
            ras_q <= '0;
            rc_q  <= '0;
            rp_q  <= '0;
            ap_q  <= '0;
        end else begin
            rcd_q <= act_go   ? LD_RCD          : step_down(rcd_q);
            ras_q <= act_go   ? LD_RAS          : step_down(ras_q);
            rc_q  <= act_go   ? LD_RC           : step_down(rc_q);
            ap_q  <= ap_go    ? ap_delay - CW'(1) : step_down(ap_q);
            rp_q  <= to_prech ? LD_RP           : step_down(rp_q);
        end
    end

    always_comb begin
        state    = st_q;
        rcd_ok   = (rcd_q == '0);
        rc_ok    = (rc_q == '0);
        ras_left = ras_q;
        ready    = (st_q == BK_IDLE) || (st_q == BK_PRECH && rp_q == '0);
    end

endmodule

// File: rtl/sdram_gate_globals.sv
module sdram_gate_globals
    import sdram_gate_pkg::*;
#(
    parameter int CW    = 6,
    parameter int T_RRD = 2,
    parameter int T_RC  = 9,
    parameter int T_RSC = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       act_go,
    input  logic       ref_go,
    input  logic       mrs_go,
    input  logic [2:0] mode_bl,
    output logic       rrd_ok,
    output logic       ref_ok,
    output logic       rsc_ok,
    output logic [2:0] bl_code
);

    localparam logic [CW-1:0] LD_RRD = CW'(T_RRD - 1);
    localparam logic [CW-1:0] LD_RC  = CW'(T_RC - 1);
    localparam logic [CW-1:0] LD_RSC = CW'(T_RSC - 1);

    logic [CW-1:0] rrd_q, ref_q, rsc_q;
    logic [2:0]    bl_q;

    function automatic logic [CW-1:0] step_down(input logic [CW-1:0] v);
        return (v == '0) ? v : v - CW'(1);
    endfunction

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rrd_q <= '0;
            ref_q <= '0;
            rsc_q <= '0;
            bl_q  <= BL_CODE_RESET;
        end else begin
            rrd_q <= act_go ? LD_RRD : step_down(rrd_q);
            ref_q <= ref_go ? LD_RC  : step_down(ref_q);
            rsc_q <= mrs_go ? LD_RSC : step_down(rsc_q);
            if (mrs_go) bl_q <= mode_bl;
        end
    end

    always_comb begin
        rrd_ok  = (rrd_q == '0);
        ref_ok  = (ref_q == '0);
        rsc_ok  = (rsc_q == '0);
        bl_code = bl_q;
    end

endmodule

// File: rtl/sdram_bank_gate.sv
module sdram_bank_gate
    import sdram_gate_pkg::*;
#(
    parameter int NB    = 4,
    parameter int T_RCD = 3,
    parameter int T_RAS = 6,
    parameter int T_RC  = 9,
    parameter int T_RRD = 2,
    parameter int T_RP  = 3,
    parameter int T_WR  = 2,
    parameter int T_RSC = 2
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [3:0]              cmd,
    input  logic [$clog2(NB)-1:0]   bank,
    input  logic [2:0]              mode_bl,
    output logic [NB-1:0]           may_act,
    output logic [NB-1:0]           may_rw,
    output logic [NB-1:0]           may_rda,
    output logic [NB-1:0]           may_wra,
    output logic [NB-1:0]           may_pre,
    output logic                    may_prea,
    output logic                    may_ref,
    output logic                    may_mrs,
    output logic                    violation
);

    localparam int BW = $clog2(NB);
    localparam int CW = $clog2(T_RC + T_RAS + T_RCD + T_RP + T_WR + T_RRD + T_RSC + 16);

    bank_state_e [NB-1:0]   bst;
    logic [NB-1:0]          rdy, rcd_ok, rc_ok;
    logic [NB-1:0][CW-1:0]  ras_left;
    logic [NB-1:0]          act_go, ap_go, pre_go;
    logic                   rrd_ok, ref_ok, rsc_ok;
    logic [2:0]             bl_code;
    logic                   full_page, cmd_ok, accept;
    logic [CW-1:0]          beats, rd_delay, wr_delay, ap_delay;

    assign full_page = bl_code[2];
    assign beats     = CW'(1) << bl_code[1:0];
    assign rd_delay  = beats;
    assign wr_delay  = beats - CW'(1) + CW'(T_WR);
    assign ap_delay  = (cmd == CMD_WRA) ? wr_delay : rd_delay;

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            logic rw_ok;
            rw_ok      = rsc_ok && (bst[i] == BK_OPEN) && rcd_ok[i];
            may_act[i] = rsc_ok && rdy[i] && rc_ok[i] && rrd_ok && ref_ok;
            may_rw[i]  = rw_ok;
            may_rda[i] = rw_ok && !full_page && (ras_left[i] <= rd_delay);
            may_wra[i] = rw_ok && !full_page && (ras_left[i] <= wr_delay);
            may_pre[i] = rsc_ok && (bst[i] != BK_AUTO) &&
                         (bst[i] != BK_OPEN || ras_left[i] == '0);
        end
        may_prea = &may_pre;
        may_mrs  = rsc_ok && (&rdy);
        may_ref  = rsc_ok && (&rdy) && (&rc_ok) && ref_ok;
    end

    always_comb begin
        unique case (cmd)
            CMD_NOP:          cmd_ok = 1'b1;
            CMD_ACT:          cmd_ok = may_act[bank];
            CMD_RD, CMD_WR:   cmd_ok = may_rw[bank];
            CMD_RDA:          cmd_ok = may_rda[bank];
            CMD_WRA:          cmd_ok = may_wra[bank];
            CMD_PRE:          cmd_ok = may_pre[bank];
            CMD_PREA:         cmd_ok = may_prea;
            CMD_REF:          cmd_ok = may_ref;
            CMD_MRS:          cmd_ok = may_mrs;
            default:          cmd_ok = 1'b0;
        endcase
        violation = !cmd_ok;
        accept    = cmd_ok && (cmd != CMD_NOP);
    end

    always_comb begin
        for (int i = 0; i < NB; i++) begin
            logic hit;
            hit       = (bank == BW'(i));
            act_go[i] = accept && (cmd == CMD_ACT) && hit;
            ap_go[i]  = accept && (cmd == CMD_RDA || cmd == CMD_WRA) && hit;
            pre_go[i] = accept && ((cmd == CMD_PRE && hit) || cmd == CMD_PREA);
        end
    end

    for (genvar gi = 0; gi < NB; gi++) begin : g_bank
        sdram_bank_fsm #(
            .CW(CW), .T_RCD(T_RCD), .T_RAS(T_RAS), .T_RC(T_RC), .T_RP(T_RP)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_go   (act_go[gi]),
            .ap_go    (ap_go[gi]),
            .pre_go   (pre_go[gi]),
            .ap_delay (ap_delay),
            .state    (bst[gi]),
            .rcd_ok   (rcd_ok[gi]),
            .rc_ok    (rc_ok[gi]),
            .ready    (rdy[gi]),
            .ras_left (ras_left[gi])
        );
    end

    sdram_gate_globals #(
        .CW(CW), .T_RRD(T_RRD), .T_RC(T_RC), .T_RSC(T_RSC)
    ) u_glob (
        .clk     (clk),
        .rst_n   (rst_n),
        .act_go  (accept && cmd == CMD_ACT),
        .ref_go  (accept && cmd == CMD_REF),
        .mrs_go  (accept && cmd == CMD_MRS),
        .mode_bl (mode_bl),
        .rrd_ok  (rrd_ok),
        .ref_ok  (ref_ok),
        .rsc_ok  (rsc_ok),
        .bl_code (bl_code)
    );

endmodule

// File: rtl/sdram_gate_chk.sv
module sdram_gate_chk
    import sdram_gate_pkg::*;
#(
    parameter int NB    = 4,
    parameter int T_RCD = 3,
    parameter int T_RRD = 2,
    parameter int T_RSC = 2
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic [3:0]            cmd,
    input logic [$clog2(NB)-1:0] bank,
    input logic                  violation,
    input logic [NB-1:0]         may_act,
    input logic [NB-1:0]         may_rw,
    input logic [NB-1:0]         may_rda,
    input logic [NB-1:0]         may_wra,
    input logic [NB-1:0]         may_pre,
    input logic                  may_prea,
    input logic                  may_ref,
    input logic                  may_mrs,
    input logic                  full_page,
    input bank_state_e [NB-1:0]  bstate
);

    localparam int BW = $clog2(NB);

    for (genvar b = 0; b < NB; b++) begin : g_bk
        if (T_RCD > 1) begin : g_rcd
            AST_RCD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
                (cmd == CMD_ACT && !violation && bank == BW'(b)) |=> !may_rw[b]); // R2
        end
        AST_NO_REOPEN: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && !violation && bank == BW'(b)) |=> !may_act[b]); // R3
        AST_AP_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
            ((cmd == CMD_RDA || cmd == CMD_WRA) && !violation && bank == BW'(b))
            |=> (!may_rw[b] && !may_pre[b] && !may_prea)); // R10
        AST_DROP_ACT: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && violation && bank == BW'(b) && bstate[b] == BK_IDLE)
            |=> (bstate[b] == BK_IDLE)); // R14
    end

    if (T_RRD > 1) begin : g_rrd
        AST_RRD_GAP: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_ACT && !violation) |=> (may_act == '0)); // R5
    end

    if (T_RSC > 1) begin : g_rsc
        AST_RSC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd == CMD_MRS && !violation) |=> (may_act == '0 && !may_ref && !may_mrs)); // R11
    end

    AST_REF_ALL_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        may_ref |-> may_mrs); // R4
    AST_FULL_NO_AP: assert property (@(posedge clk) disable iff (!rst_n)
        full_page |-> (may_rda == '0 && may_wra == '0)); // R11
    AST_NOP_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd == CMD_NOP) |-> !violation); // R14

endmodule

bind sdram_bank_gate sdram_gate_chk #(
    .NB(NB), .T_RCD(T_RCD), .T_RRD(T_RRD), .T_RSC(T_RSC)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd       (cmd),
    .bank      (bank),
    .violation (violation),
    .may_act   (may_act),
    .may_rw    (may_rw),
    .may_rda   (may_rda),
    .may_wra   (may_wra),
    .may_pre   (may_pre),
    .may_prea  (may_prea),
    .may_ref   (may_ref),
    .may_mrs   (may_mrs),
    .full_page (full_page),
    .bstate    (bst)
);

// File: tb/test_sdram_bank_gate.sv
module test_sdram_bank_gate;
    import sdram_gate_pkg::*;

    localparam int NB = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] cmd = CMD_NOP;
    logic [1:0] bank = '0;
    logic [2:0] mode_bl = '0;
    logic [NB-1:0] may_act, may_rw, may_rda, may_wra, may_pre;
    logic       may_prea, may_ref, may_mrs, violation;

    int n_chk = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    sdram_bank_gate #(.NB(NB), .T_RC(10)) i_sdram_bank_gate (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .bank(bank), .mode_bl(mode_bl),
        .may_act(may_act), .may_rw(may_rw), .may_rda(may_rda), .may_wra(may_wra),
        .may_pre(may_pre), .may_prea(may_prea), .may_ref(may_ref),
        .may_mrs(may_mrs), .violation(violation)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        cmd = CMD_NOP;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic issue(input logic [3:0] c, input int b, input bit legal, input string req);
        @(negedge clk);
        cmd = c;
        bank = 2'(b);
        #1;
        chk(violation == !legal, req, "violation", int'(violation), int'(!legal));
    endtask

    task automatic idle(input int n);
        repeat (n) begin
            @(negedge clk);
            cmd = CMD_NOP;
        end
        #1;
    endtask

    task automatic set_bl(input logic [2:0] code);
        mode_bl = code;
        issue(CMD_MRS, 0, 1'b1, "R11");
        idle(1);
    endtask

    task automatic t_reset();
        do_reset();
        idle(1);
        chk(may_act == 4'hF, "R1", "may_act", int'(may_act), 15);
        chk(may_rw == 4'h0 && may_rda == 4'h0 && may_wra == 4'h0, "R1", "may_rw",
            int'(may_rw), 0);
        chk(may_pre == 4'hF && may_prea, "R1", "may_pre", int'(may_pre), 15);
        chk(may_ref && may_mrs && !violation, "R1", "ref/mrs", int'(may_ref), 1);
    endtask

    task automatic t_rcd();
        do_reset();
        issue(CMD_ACT, 0, 1'b1, "R2");
        idle(1);
        issue(CMD_RD, 0, 1'b0, "R2");
        issue(CMD_RD, 0, 1'b1, "R2");
        issue(CMD_RD, 0, 1'b1, "R12");
        issue(CMD_WR, 0, 1'b1, "R12");
        issue(CMD_WR, 1, 1'b0, "R14");
        issue(4'd12, 0, 1'b0, "R14");
    endtask

    task automatic t_rrd();
        do_reset();
        issue(CMD_ACT, 0, 1'b1, "R5");
        issue(CMD_ACT, 1, 1'b0, "R5");
        idle(1);
        chk(may_act == 4'b1110, "R5", "may_act after gap", int'(may_act), 14);
        idle(2);
        chk(may_rw == 4'b0001, "R14", "dropped activate left bank idle", int'(may_rw), 1);
        issue(CMD_ACT, 1, 1'b1, "R5");
        issue(CMD_ACT, 0, 1'b0, "R3");
    endtask

    task automatic t_ras_rp_rc();
        do_reset();
        issue(CMD_ACT, 0, 1'b1, "R7");
        idle(4);
        issue(CMD_PRE, 0, 1'b0, "R7");
        issue(CMD_PRE, 0, 1'b1, "R7");
        issue(CMD_ACT, 0, 1'b0, "R6");
        issue(CMD_ACT, 0, 1'b0, "R6");
        issue(CMD_ACT, 0, 1'b0, "R4");
        issue(CMD_ACT, 0, 1'b1, "R4");
    endtask

    task automatic t_refresh();
        do_reset();
        issue(CMD_ACT, 2, 1'b1, "R4");
        issue(CMD_REF, 0, 1'b0, "R4");
        do_reset();
        issue(CMD_REF, 0, 1'b1, "R4");
        idle(8);
        issue(CMD_ACT, 0, 1'b0, "R4");
        issue(CMD_ACT, 0, 1'b1, "R4");
    endtask

    task automatic t_read_ap();
        do_reset();
        issue(CMD_ACT, 1, 1'b1, "R8");
        idle(3);
        issue(CMD_RDA, 1, 1'b1, "R8");
        issue(CMD_RD, 1, 1'b0, "R10");
        issue(CMD_PRE, 1, 1'b0, "R10");
        issue(CMD_PREA, 0, 1'b0, "R10");
        idle(2);
        issue(CMD_ACT, 1, 1'b0, "R8");
        issue(CMD_ACT, 1, 1'b1, "R8");
    endtask

    task automatic t_write_ap();
        do_reset();
        mode_bl = 3'd3;
        issue(CMD_MRS, 0, 1'b1, "R11");
        issue(CMD_ACT, 0, 1'b0, "R11");
        issue(CMD_ACT, 0, 1'b1, "R9");
        idle(2);
        issue(CMD_WRA, 0, 1'b1, "R9");
        idle(10);
        issue(CMD_ACT, 0, 1'b0, "R9");
        issue(CMD_ACT, 0, 1'b1, "R9");
    endtask

    task automatic t_ap_ras();
        do_reset();
        set_bl(3'd0);
        issue(CMD_ACT, 3, 1'b1, "R7");
        idle(2);
        issue(CMD_RDA, 3, 1'b0, "R7");
        issue(CMD_WRA, 3, 1'b1, "R7");
    endtask

    task automatic t_full_page();
        do_reset();
        set_bl(3'd7);
        issue(CMD_ACT, 2, 1'b1, "R11");
        idle(2);
        issue(CMD_RDA, 2, 1'b0, "R11");
        issue(CMD_WRA, 2, 1'b0, "R11");
        issue(CMD_RD, 2, 1'b1, "R11");
        chk(may_rda == 4'h0 && may_wra == 4'h0, "R11", "auto-precharge flags",
            int'(may_rda), 0);
    endtask

    task automatic t_prea();
        do_reset();
        issue(CMD_ACT, 0, 1'b1, "R13");
        idle(1);
        issue(CMD_ACT, 2, 1'b1, "R13");
        idle(4);
        issue(CMD_PREA, 0, 1'b0, "R13");
        issue(CMD_PREA, 0, 1'b1, "R13");
        idle(2);
        chk(may_act[0] == 1'b0, "R13", "bank0 in tRP", int'(may_act[0]), 0);
        chk(may_act[1] == 1'b1, "R13", "closed bank ready", int'(may_act[1]), 1);
        issue(CMD_ACT, 0, 1'b1, "R13");
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_rcd();
        t_rrd();
        t_ras_rp_rc();
        t_refresh();
        t_read_ap();
        t_write_ap();
        t_ap_ras();
        t_full_page();
        t_prea();
        idle(2);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule